// File: doc/BRIEF.md
# USB Host Controller Register File

This block holds the software-visible registers of a two-port, full/low-speed USB host controller. Software reaches it over a small I/O bus with 32 bytes of address space. The bus carries byte, 16-bit word and 32-bit accesses. The block stores the command word, the interrupt status, the interrupt enables, the frame counter, the frame-list base address, the start-of-frame timing byte and one status/control word per root port. From these it drives a level-sensitive interrupt line.

The schedule engine sits next to this block and is connected only through simple signals. The block tells it to run, and gives a one-cycle start pulse when software switches run on. The engine reports the end of each frame together with the completion and short-packet causes collected during that frame. It can also report a transfer error, a host system error or a process error. Root-port hardware reports device connect, disconnect and speed. In return the block pulses a bus reset toward attached devices on a global reset, and a port reset when software raises the reset bit of an occupied port.

Top module: `usbh_regfile`

## Requirements
- R1: After reset the registers read back as follows:
  - command, status, interrupt enable, frame number and base address all read 0;
  - the timing byte reads 64;
  - each port reads 0x0080;
  - `irq` and `frame_run` are low.
- R2: The access width is coded on `bus_size` as 0 = byte, 1 = word, 2 = dword and 3 = invalid. Reads of unmapped locations return fixed values:
  - a byte read of any offset other than 0x0C returns 0xFF;
  - a dword read of any offset other than 0x08 returns 0xFFFFFFFF, and so does any read of width 3;
  - a word read of an unmapped offset, including a port index of 2 or more, returns 0xFF7F.
  
  The timing byte at 0x0C stores byte writes.
- R3: A word write to offset 0 with bit 0 = 1 while bit 0 of the command was 0 clears status bit 5 (halted). It also gives a one-cycle `frame_start` pulse in the cycle after the write. A write with bit 0 = 0 sets status bit 5. `frame_run` follows command bit 0.
- R4: The frame number at offset 6 is 11 bits wide. A write to it takes effect only while status bit 5 is set. Each `frame_end` while running adds one, modulo 2048.
- R5: A dword write to offset 0x08 stores the value with bits 11:0 forced to zero.
- R6: Status bits 5:0 at offset 2 are cleared by writing 1 to them. Writing 1 to bit 0 also clears both hidden cause bits.
- R7: `irq` is high when any of these holds:
  - cause 0 and enable bit 2 are both set;
  - cause 1 and enable bit 3 are both set;
  - status bit 1 and enable bit 0 are both set;
  - status bit 2 and enable bit 1 are both set;
  - status bit 3 is set;
  - status bit 4 is set.
  
  The error inputs set status bits 1, 3 and 4 respectively.
- R8: A command write with bit 1 or bit 2 set does not store the command. Instead it returns command, status, enables, base, timing byte and causes to their reset values. The frame number is kept. Each port returns to 0x0080, and an occupied port then also shows bits 0 and 1, with bit 8 set to its speed.
- R9: A command write with bit 2 set pulses `bus_reset` for every occupied port in the cycle after the write. Bit 1 alone pulses nothing.
- R10: A word write to port n (offsets 0x10 + 2n) updates the port word in two steps. Bits 0, 1 and 3..8 keep their value and bits 2 and 9..15 take the written value. Bits 1 and 3 are then cleared wherever the written value has a 1.
- R11: A port write that sets bit 9 while bit 9 was 0 and a device is present pulses `port_reset` for that port in the next cycle. No other port write pulses it.
- R12: A connect sets bits 0 and 1 and copies the speed into bit 8. A disconnect clears bit 0 and sets bit 1. If bit 2 was set, the disconnect also clears it and sets bit 3.
- R13: A connect or disconnect while command bit 3 is set sets command bit 4 and status bit 2. Without bit 3 it changes neither.
- R14: A `frame_end` while running ORs `frame_cause` into the causes and sets status bit 0 if the cause is nonzero. While stopped, `frame_end` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_size | input | 2 | Access width: 0 byte, 1 word, 2 dword |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data, right aligned |
| bus_rdata | output | 32 | Read data for the current address and width |
| dev_attach | input | NPORTS | One-cycle connect event per port |
| dev_detach | input | NPORTS | One-cycle disconnect event per port |
| dev_low_speed | input | NPORTS | Speed of the connecting device (1 = low) |
| frame_end | input | 1 | End of a frame from the schedule engine |
| frame_cause | input | 2 | Causes seen in that frame: bit 0 completion, bit 1 short packet |
| xfer_err | input | 1 | Transfer error event |
| host_err | input | 1 | Host system error event |
| proc_err | input | 1 | Process error event |
| irq | output | 1 | Level interrupt |
| frame_run | output | 1 | Run request to the schedule engine |
| frame_start | output | 1 | Pulse when run is switched on |
| bus_reset | output | NPORTS | Bus reset pulse per occupied port |
| port_reset | output | NPORTS | Port reset pulse |

## Verification
Any fault in the stored state shows up on the very next read of the affected offset, because reads are combinational. A wrong cause or status bit shows on `irq` in the same cycle. A corrupted port merge appears as a wrong port word on the read that follows the write. The near-exhaustive interrupt sweep exposes a wrong enable pairing within one enable change. A lost or duplicated reset pulse is visible exactly one cycle after the command or port write.

// File: rtl/usbh_pkg.sv
`timescale 1ns/1ps
package usbh_pkg;
  localparam int CMD_RUN  = 0;
  localparam int CMD_HRST = 1;
  localparam int CMD_GRST = 2;
  localparam int CMD_SUSP = 3;
  localparam int CMD_FRES = 4;

  localparam int ST_XFER = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_RES  = 2;
  localparam int ST_SYS  = 3;
  localparam int ST_PROC = 4;
  localparam int ST_HALT = 5;
  localparam int ST_W    = 6;

  localparam int PB_CONN     = 0;
  localparam int PB_CONN_CHG = 1;
  localparam int PB_EN       = 2;
  localparam int PB_EN_CHG   = 3;
  localparam int PB_LOWSPD   = 8;
  localparam int PB_RESET    = 9;

  localparam logic [15:0] PORT_KEEP  = 16'h01FB;
  localparam logic [15:0] PORT_W1C   = 16'h000A;
  localparam logic [15:0] PORT_INIT  = 16'h0080;
  localparam logic [15:0] WORD_VOID  = 16'hFF7F;
  localparam logic [7:0]  SOF_INIT   = 8'd64;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_WORD  = 2'd1,
    ACC_DWORD = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  // keep-masked merge followed by write-one-to-clear of change bits
  function automatic logic [15:0] port_merge(input logic [15:0] cur, input logic [15:0] wv);
    logic [15:0] m;
    m = (cur & PORT_KEEP) | (wv & ~PORT_KEEP);
    return m & ~(wv & PORT_W1C);
  endfunction

  function automatic logic [15:0] port_init(input logic present, input logic low);
    return present ? (PORT_INIT | {7'b0, low, 8'h03}) : PORT_INIT;
  endfunction

  function automatic logic irq_level(input logic [1:0] cause, input logic [15:0] en,
                                     input logic [ST_W-1:0] st);
    return (cause[0] & en[2]) | (cause[1] & en[3]) |
           (st[ST_ERR] & en[0]) | (st[ST_RES] & en[1]) |
           st[ST_SYS] | st[ST_PROC];
  endfunction
endpackage

// File: rtl/usbh_port.sv
`timescale 1ns/1ps
module usbh_port
  import usbh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        glob_rst,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        attach_evt,
  input  logic        detach_evt,
  input  logic        low_speed,
  output logic [15:0] ctrl_q,
  output logic        resume_req,
  output logic        port_rst_q,
  output logic        bus_rst_q
);
  logic        att_q, ls_q, att_n, ls_n, prst_n;
  logic [15:0] ctrl_n;

  always_comb begin
    ctrl_n     = ctrl_q;
    att_n      = att_q;
    ls_n       = ls_q;
    resume_req = 1'b0;
    prst_n     = 1'b0;
    if (soft_rst) begin
      ctrl_n = port_init(att_q, ls_q);
    end else if (wr_en) begin
      prst_n = att_q & wdata[PB_RESET] & ~ctrl_q[PB_RESET];
      ctrl_n = port_merge(ctrl_q, wdata);
    end
    // a connect on an occupied port first drops the old device
    if (detach_evt || (attach_evt && att_q)) begin
      if (ctrl_n[PB_CONN]) begin
        ctrl_n[PB_CONN]     = 1'b0;
        ctrl_n[PB_CONN_CHG] = 1'b1;
      end
      if (ctrl_n[PB_EN]) begin
        ctrl_n[PB_EN]     = 1'b0;
        ctrl_n[PB_EN_CHG] = 1'b1;
      end
      att_n      = 1'b0;
      resume_req = 1'b1;
    end
    if (attach_evt) begin
      ctrl_n[PB_CONN]     = 1'b1;
      ctrl_n[PB_CONN_CHG] = 1'b1;
      ctrl_n[PB_LOWSPD]   = low_speed;
      att_n               = 1'b1;
      ls_n                = low_speed;
      resume_req          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= PORT_INIT;
      att_q      <= 1'b0;
      ls_q       <= 1'b0;
      port_rst_q <= 1'b0;
      bus_rst_q  <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_n;
      att_q      <= att_n;
      ls_q       <= ls_n;
      port_rst_q <= prst_n;
      bus_rst_q  <= glob_rst & att_q;
    end
  end
endmodule

// File: rtl/usbh_ctrl.sv
`timescale 1ns/1ps
module usbh_ctrl
  import usbh_pkg::*;
#(
  parameter int FRNUM_W  = 11,
  parameter int BASE_LSB = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_cmd,
  input  logic               wr_sts,
  input  logic               wr_intr,
  input  logic               wr_frnum,
  input  logic               wr_base,
  input  logic               wr_sof,
  input  logic [31:0]        wdata,
  input  logic               frame_end,
  input  logic [1:0]         frame_cause,
  input  logic               xfer_err,
  input  logic               sys_err,
  input  logic               proc_err,
  input  logic               resume_req,
  output logic [15:0]        cmd_q,
  output logic [ST_W-1:0]    sts_q,
  output logic [15:0]        intr_q,
  output logic [FRNUM_W-1:0] frnum_q,
  output logic [31:0]        base_q,
  output logic [7:0]         sof_q,
  output logic [1:0]         cause_q,
  output logic               soft_rst,
  output logic               glob_rst,
  output logic               frame_start_q,
  output logic               irq
);
  localparam logic [31:0] BASE_MASK = ~((32'd1 << BASE_LSB) - 32'd1);

  logic [15:0]        cmd_n, intr_n;
  logic [ST_W-1:0]    sts_n;
  logic [FRNUM_W-1:0] frnum_n;
  logic [31:0]        base_n;
  logic [7:0]         sof_n;
  logic [1:0]         cause_n;
  logic               start_n;

  assign soft_rst = wr_cmd & (wdata[CMD_HRST] | wdata[CMD_GRST]);
  assign glob_rst = wr_cmd & wdata[CMD_GRST];
  assign irq      = irq_level(cause_q, intr_q, sts_q);

  always_comb begin
    cmd_n   = cmd_q;
    sts_n   = sts_q;
    intr_n  = intr_q;
    frnum_n = frnum_q;
    base_n  = base_q;
    sof_n   = sof_q;
    cause_n = cause_q;
    start_n = 1'b0;
    if (soft_rst) begin
      cmd_n   = '0;
      sts_n   = '0;
      intr_n  = '0;
      base_n  = '0;
      sof_n   = SOF_INIT;
      cause_n = '0;
    end else if (wr_cmd) begin
      if (wdata[CMD_RUN] && !cmd_q[CMD_RUN]) begin
        sts_n[ST_HALT] = 1'b0;
        start_n        = 1'b1;
      end else if (!wdata[CMD_RUN]) begin
        sts_n[ST_HALT] = 1'b1;
      end
      cmd_n = wdata[15:0];
    end
    if (wr_sts) begin
      sts_n = sts_n & ~wdata[ST_W-1:0];
      if (wdata[ST_XFER]) cause_n = '0;
    end
    if (wr_intr) intr_n = wdata[15:0];
    if (wr_frnum && sts_q[ST_HALT]) frnum_n = wdata[FRNUM_W-1:0];
    if (wr_base) base_n = wdata & BASE_MASK;
    if (wr_sof) sof_n = wdata[7:0];
    if (frame_end && cmd_q[CMD_RUN]) begin
      if (frame_cause != 2'b00) begin
        cause_n        = cause_n | frame_cause;
        sts_n[ST_XFER] = 1'b1;
      end
      frnum_n = frnum_n + FRNUM_W'(1);
    end
    if (xfer_err) sts_n[ST_ERR]  = 1'b1;
    if (sys_err)  sts_n[ST_SYS]  = 1'b1;
    if (proc_err) sts_n[ST_PROC] = 1'b1;
    if (resume_req && cmd_n[CMD_SUSP]) begin
      cmd_n[CMD_FRES] = 1'b1;
      sts_n[ST_RES]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q         <= '0;
      sts_q         <= '0;
      intr_q        <= '0;
      frnum_q       <= '0;
      base_q        <= '0;
      sof_q         <= SOF_INIT;
      cause_q       <= '0;
      frame_start_q <= 1'b0;
    end else begin
      cmd_q         <= cmd_n;
      sts_q         <= sts_n;
      intr_q        <= intr_n;
      frnum_q       <= frnum_n;
      base_q        <= base_n;
      sof_q         <= sof_n;
      cause_q       <= cause_n;
      frame_start_q <= start_n;
    end
  end
endmodule

// File: rtl/usbh_rdmux.sv
`timescale 1ns/1ps
module usbh_rdmux
  import usbh_pkg::*;
#(
  parameter int NPORTS  = 2,
  parameter int FRNUM_W = 11
) (
  input  logic [1:0]              size,
  input  logic [4:0]              addr,
  input  logic [15:0]             cmd_q,
  input  logic [ST_W-1:0]         sts_q,
  input  logic [15:0]             intr_q,
  input  logic [FRNUM_W-1:0]      frnum_q,
  input  logic [31:0]             base_q,
  input  logic [7:0]              sof_q,
  input  logic [NPORTS-1:0][15:0] port_ctrl,
  output logic [31:0]             rdata
);
  logic [15:0] wv;

  always_comb begin
    wv = WORD_VOID;
    case (addr)
      5'h00: wv = cmd_q;
      5'h02: wv = 16'(sts_q);
      5'h04: wv = intr_q;
      5'h06: wv = 16'(frnum_q);
      default: begin
        for (int i = 0; i < NPORTS; i++) begin
          if (addr[4] && addr[3:1] == 3'(i)) wv = port_ctrl[i];
        end
      end
    endcase
  end

  always_comb begin
    case (acc_e'(size))
      ACC_BYTE:  rdata = (addr == 5'h0C) ? {24'h0, sof_q} : 32'h0000_00FF;
      ACC_WORD:  rdata = {16'h0, wv};
      ACC_DWORD: rdata = (addr == 5'h08) ? base_q : 32'hFFFF_FFFF;
      default:   rdata = 32'hFFFF_FFFF;
    endcase
  end
endmodule

// File: rtl/usbh_regfile.sv
`timescale 1ns/1ps
module usbh_regfile
  import usbh_pkg::*;
#(
  parameter int NPORTS   = 2,
  parameter int FRNUM_W  = 11,
  parameter int BASE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPORTS-1:0] dev_attach,
  input  logic [NPORTS-1:0] dev_detach,
  input  logic [NPORTS-1:0] dev_low_speed,
  input  logic              frame_end,
  input  logic [1:0]        frame_cause,
  input  logic              xfer_err,
  input  logic              host_err,
  input  logic              proc_err,
  output logic              irq,
  output logic              frame_run,
  output logic              frame_start,
  output logic [NPORTS-1:0] bus_reset,
  output logic [NPORTS-1:0] port_reset
);
  logic wr_b, wr_w, wr_d;
  logic wr_cmd, wr_sts, wr_intr, wr_frnum, wr_base, wr_sof;
  logic soft_rst, glob_rst, resume_any;

  logic [15:0]             cmd_q, intr_q;
  logic [ST_W-1:0]         sts_q;
  logic [FRNUM_W-1:0]      frnum_q;
  logic [31:0]             base_q;
  logic [7:0]              sof_q;
  logic [1:0]              cause_q;
  logic [NPORTS-1:0][15:0] port_ctrl;
  logic [NPORTS-1:0]       port_wr, port_resume, port_bit9;
  logic                    base_rd;

  assign wr_b     = bus_wr & (bus_size == ACC_BYTE);
  assign wr_w     = bus_wr & (bus_size == ACC_WORD);
  assign wr_d     = bus_wr & (bus_size == ACC_DWORD);
  assign wr_cmd   = wr_w & (bus_addr == 5'h00);
  assign wr_sts   = wr_w & (bus_addr == 5'h02);
  assign wr_intr  = wr_w & (bus_addr == 5'h04);
  assign wr_frnum = wr_w & (bus_addr == 5'h06);
  assign wr_base  = wr_d & (bus_addr == 5'h08);
  assign wr_sof   = wr_b & (bus_addr == 5'h0C);
  assign base_rd  = (bus_size == ACC_DWORD) && (bus_addr == 5'h08);

  assign resume_any = |port_resume;
  assign frame_run  = cmd_q[CMD_RUN];

  usbh_ctrl #(.FRNUM_W(FRNUM_W), .BASE_LSB(BASE_LSB)) u_ctrl (
    .clk, .rst_n,
    .wr_cmd, .wr_sts, .wr_intr, .wr_frnum, .wr_base, .wr_sof,
    .wdata(bus_wdata),
    .frame_end, .frame_cause, .xfer_err,
    .sys_err(host_err), .proc_err,
    .resume_req(resume_any),
    .cmd_q, .sts_q, .intr_q, .frnum_q, .base_q, .sof_q, .cause_q,
    .soft_rst, .glob_rst,
    .frame_start_q(frame_start),
    .irq
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    assign port_wr[g]   = wr_w & bus_addr[4] & (bus_addr[3:1] == 3'(g));
    assign port_bit9[g] = port_ctrl[g][PB_RESET];
    usbh_port u_port (
      .clk, .rst_n, .soft_rst, .glob_rst,
      .wr_en(port_wr[g]),
      .wdata(bus_wdata[15:0]),
      .attach_evt(dev_attach[g]),
      .detach_evt(dev_detach[g]),
      .low_speed(dev_low_speed[g]),
      .ctrl_q(port_ctrl[g]),
      .resume_req(port_resume[g]),
      .port_rst_q(port_reset[g]),
      .bus_rst_q(bus_reset[g])
    );
  end

  usbh_rdmux #(.NPORTS(NPORTS), .FRNUM_W(FRNUM_W)) u_rdmux (
    .size(bus_size), .addr(bus_addr),
    .cmd_q, .sts_q, .intr_q, .frnum_q, .base_q, .sof_q, .port_ctrl,
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/usbh_regfile_chk.sv
`timescale 1ns/1ps
module usbh_regfile_chk #(
  parameter int NPORTS  = 2,
  parameter int FRNUM_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_run,
  input logic [5:0]         sts,
  input logic               frame_start,
  input logic [FRNUM_W-1:0] frnum,
  input logic               frnum_wr,
  input logic               sts_wr,
  input logic [31:0]        wdata,
  input logic               frame_end,
  input logic [1:0]         cause,
  input logic               irq,
  input logic [NPORTS-1:0]  port_rst,
  input logic [NPORTS-1:0]  port_bit9,
  input logic               base_rd,
  input logic [31:0]        rdata
);
  assert_start_clears_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (cmd_run && !sts[5]));

  assert_run_not_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_run |-> !sts[5]);

  assert_frnum_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_run && !frnum_wr) |=> $stable(frnum));

  assert_base_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    base_rd |-> (rdata[11:0] == 12'h000));

  assert_cause_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wdata[0] && !frame_end) |=> (cause == 2'b00));

  assert_err_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[3] || sts[4]) |-> irq);

  for (genvar g = 0; g < NPORTS; g++) begin : g_chk
    assert_port_reset_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      port_rst[g] |-> port_bit9[g]);
  end
endmodule

bind usbh_regfile usbh_regfile_chk #(.NPORTS(NPORTS), .FRNUM_W(FRNUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_run(frame_run), .sts(sts_q),
  .frame_start(frame_start), .frnum(frnum_q), .frnum_wr(wr_frnum),
  .sts_wr(wr_sts), .wdata(bus_wdata), .frame_end(frame_end), .cause(cause_q),
  .irq(irq), .port_rst(port_reset), .port_bit9(port_bit9),
  .base_rd(base_rd), .rdata(bus_rdata)
);

// File: tb/sim_usbh_regfile.sv
`timescale 1ns/1ps
module sim_usbh_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_size = 2'd1;
  logic [4:0]  bus_addr = 5'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [1:0]  dev_attach = 2'b00, dev_detach = 2'b00, dev_low_speed = 2'b00;
  logic        frame_end = 1'b0;
  logic [1:0]  frame_cause = 2'b00;
  logic        xfer_err = 1'b0, host_err = 1'b0, proc_err = 1'b0;
  logic        irq, frame_run, frame_start;
  logic [1:0]  bus_reset, port_reset;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic       cap_fs;
  logic [1:0] cap_bus, cap_prst;
  logic [31:0] q;

  always #2.5 clk = ~clk;

  usbh_regfile u0 (
    .clk, .rst_n, .bus_wr, .bus_size, .bus_addr, .bus_wdata, .bus_rdata,
    .dev_attach, .dev_detach, .dev_low_speed, .frame_end, .frame_cause,
    .xfer_err, .host_err, .proc_err, .irq, .frame_run, .frame_start,
    .bus_reset, .port_reset
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    cap_fs = frame_start; cap_bus = bus_reset; cap_prst = port_reset;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b0; bus_size = sz; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic ev(input logic [1:0] att, input logic [1:0] det, input logic [1:0] ls,
                    input logic fe, input logic [1:0] fc, input logic xe, input logic he);
    @(negedge clk);
    dev_attach = att; dev_detach = det; dev_low_speed = ls;
    frame_end = fe; frame_cause = fc; xfer_err = xe; host_err = he;
    @(negedge clk);
    dev_attach = 2'b00; dev_detach = 2'b00; frame_end = 1'b0; frame_cause = 2'b00;
    xfer_err = 1'b0; host_err = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // bench-side model of a port write, bit by bit
  function automatic logic [15:0] port_expect(input logic [15:0] prev, input logic [15:0] v);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) begin
      if (b == 2 || b >= 9) r[b] = v[b];
      else if (b == 1 || b == 3) r[b] = prev[b] & ~v[b];
      else r[b] = prev[b];
    end
    return r;
  endfunction

  initial begin
    repeat (120000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] fn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1, 5'h00, q); chk("R1 cmd", q, 32'h0);
    rd(1, 5'h02, q); chk("R1 status", q, 32'h0);
    rd(1, 5'h04, q); chk("R1 enable", q, 32'h0);
    rd(1, 5'h06, q); chk("R1 frnum", q, 32'h0);
    rd(2, 5'h08, q); chk("R1 base", q, 32'h0);
    rd(0, 5'h0C, q); chk("R1 sof", q, 32'd64);
    rd(1, 5'h10, q); chk("R1 port0", q, 32'h80);
    rd(1, 5'h12, q); chk("R1 port1", q, 32'h80);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 run", {31'h0, frame_run}, 32'h0);

    // R2 unmapped reads and the timing byte
    rd(1, 5'h14, q); chk("R2 port2 word", q, 32'hFF7F);
    rd(1, 5'h0A, q); chk("R2 word 0A", q, 32'hFF7F);
    rd(0, 5'h00, q); chk("R2 byte 00", q, 32'hFF);
    rd(2, 5'h00, q); chk("R2 dword 00", q, 32'hFFFFFFFF);
    rd(3, 5'h08, q); chk("R2 width3", q, 32'hFFFFFFFF);
    wr(0, 5'h0C, 32'h5A); rd(0, 5'h0C, q); chk("R2 sof write", q, 32'h5A);

    // R5 base alignment
    wr(2, 5'h08, 32'hDEADBEEF); rd(2, 5'h08, q); chk("R5 base", q, 32'hDEADB000);

    // R3 / R4 run, halt, frame number
    wr(1, 5'h06, 32'h123); rd(1, 5'h06, q); chk("R4 frnum blocked not halted", q, 32'h0);
    wr(1, 5'h00, 32'h0); rd(1, 5'h02, q); chk("R3 halted set", q, 32'h20);
    chk("R3 run low", {31'h0, frame_run}, 32'h0);
    wr(1, 5'h06, 32'hFFFF); rd(1, 5'h06, q); chk("R4 frnum 11 bits", q, 32'h7FF);
    wr(1, 5'h00, 32'h1);
    chk("R3 start pulse", {31'h0, cap_fs}, 32'h1);
    rd(1, 5'h02, q); chk("R3 halted cleared", q, 32'h0);
    chk("R3 run high", {31'h0, frame_run}, 32'h1);
    chk("R3 pulse single", {31'h0, frame_start}, 32'h0);
    ev(0, 0, 0, 1, 0, 0, 0); rd(1, 5'h06, q); chk("R4 wrap", q, 32'h0);
    wr(1, 5'h06, 32'h5); rd(1, 5'h06, q); chk("R4 frnum blocked running", q, 32'h0);

    // R14 / R7 / R6 causes and status
    ev(0, 0, 0, 1, 2'b10, 0, 0);
    rd(1, 5'h02, q); chk("R14 cause sets status0", q, 32'h01);
    rd(1, 5'h06, q); chk("R4 increment", q, 32'h1);
    chk("R7 no enable", {31'h0, irq}, 32'h0);
    wr(1, 5'h04, 32'h8); chk("R7 short cause", {31'h0, irq}, 32'h1);
    wr(1, 5'h04, 32'h4); chk("R7 completion not set", {31'h0, irq}, 32'h0);
    wr(1, 5'h02, 32'h1); rd(1, 5'h02, q); chk("R6 clear status0", q, 32'h0);
    wr(1, 5'h04, 32'hC); chk("R6 causes cleared", {31'h0, irq}, 32'h0);
    ev(0, 0, 0, 0, 0, 1, 1); rd(1, 5'h02, q); chk("R6 err bits", q, 32'h0A);
    chk("R7 host error", {31'h0, irq}, 32'h1);
    wr(1, 5'h02, 32'h2); rd(1, 5'h02, q); chk("R6 w1c one bit", q, 32'h08);
    wr(1, 5'h02, 32'h8); chk("R7 cleared", {31'h0, irq}, 32'h0);

    // R12 connect and disconnect
    ev(2'b10, 0, 2'b10, 0, 0, 0, 0); rd(1, 5'h12, q); chk("R12 connect low", q, 32'h183);
    ev(0, 2'b10, 0, 0, 0, 0, 0); rd(1, 5'h12, q); chk("R12 disconnect", q, 32'h182);
    wr(1, 5'h12, 32'hA); rd(1, 5'h12, q); chk("R10 w1c", q, 32'h180);
    ev(2'b01, 0, 0, 0, 0, 0, 0); rd(1, 5'h10, q); chk("R12 connect full", q, 32'h83);
    wr(1, 5'h10, 32'h6); rd(1, 5'h10, q); chk("R10 enable", q, 32'h85);
    ev(0, 2'b01, 0, 0, 0, 0, 0); rd(1, 5'h10, q); chk("R12 disconnect enabled", q, 32'h8A);
    rd(1, 5'h02, q); chk("R13 no suspend no resume", q, 32'h0);

    // R13 resume while suspended
    wr(1, 5'h00, 32'h9);
    ev(2'b01, 0, 0, 0, 0, 0, 0);
    rd(1, 5'h10, q); chk("R12 reconnect", q, 32'h8B);
    rd(1, 5'h00, q); chk("R13 force resume", q, 32'h19);
    rd(1, 5'h02, q); chk("R13 resume status", q, 32'h04);
    wr(1, 5'h02, 32'h4);

    // R11 port reset pulse
    wr(1, 5'h10, 32'h200); chk("R11 pulse", {30'h0, cap_prst}, 32'h1);
    rd(1, 5'h10, q); chk("R10 reset bit", q, 32'h28B);
    wr(1, 5'h10, 32'h200); chk("R11 no repeat", {30'h0, cap_prst}, 32'h0);
    wr(1, 5'h12, 32'h200); chk("R11 empty port", {30'h0, cap_prst}, 32'h0);

    // R8 / R9 global reset
    rd(1, 5'h06, fn);
    wr(1, 5'h00, 32'h5); chk("R9 bus reset", {30'h0, cap_bus}, 32'h1);
    rd(1, 5'h00, q); chk("R8 cmd", q, 32'h0);
    rd(1, 5'h02, q); chk("R8 status", q, 32'h0);
    rd(1, 5'h04, q); chk("R8 enable", q, 32'h0);
    rd(0, 5'h0C, q); chk("R8 sof", q, 32'd64);
    rd(2, 5'h08, q); chk("R8 base", q, 32'h0);
    rd(1, 5'h06, q); chk("R8 frnum kept", q, fn);
    rd(1, 5'h10, q); chk("R8 port0 reconnect", q, 32'h83);
    rd(1, 5'h12, q); chk("R8 port1 empty", q, 32'h80);
    ev(0, 0, 0, 1, 2'b11, 0, 0);
    rd(1, 5'h02, q); chk("R14 stopped", q, 32'h0);
    rd(1, 5'h06, q); chk("R14 frnum stopped", q, fn);

    // R8 / R9 controller-only reset
    ev(2'b10, 0, 2'b10, 0, 0, 0, 0);
    wr(1, 5'h00, 32'h2); chk("R9 no bus reset", {30'h0, cap_bus}, 32'h0);
    rd(1, 5'h12, q); chk("R8 port1 low reconnect", q, 32'h183);
    rd(1, 5'h00, q); chk("R8 cmd not stored", q, 32'h0);

    // R7 sweep over causes, error, resume and all enables
    for (int c = 0; c < 4; c++)
      for (int e = 0; e < 2; e++)
        for (int r = 0; r < 2; r++) begin
          wr(1, 5'h00, 32'h2);
          wr(1, 5'h00, (r != 0) ? 32'h9 : 32'h1);
          if (c != 0) ev(0, 0, 0, 1, 2'(c), 0, 0);
          if (e != 0) ev(0, 0, 0, 0, 0, 1, 0);
          if (r != 0) ev(2'b01, 0, 0, 0, 0, 0, 0);
          for (int en = 0; en < 16; en++) begin
            logic x;
            wr(1, 5'h04, 32'(en));
            x = (c[0] & en[2]) | (c[1] & en[3]) | (e[0] & en[0]) | (r[0] & en[1]);
            chk($sformatf("R7 c=%0d e=%0d r=%0d en=%0d", c, e, r, en), {31'h0, irq}, {31'h0, x});
          end
        end

    // R10 port merge sweep on port 1
    for (int i = 0; i < 64; i++) begin
      logic [31:0] prev;
      logic [15:0] v;
      if (i % 8 == 0) begin
        ev(0, 2'b10, 0, 0, 0, 0, 0);
        ev(2'b10, 0, 2'(i % 16 == 0 ? 2 : 0), 0, 0, 0, 0);
      end
      v = 16'(i * 40503) ^ 16'(i << 10);
      rd(1, 5'h12, prev);
      wr(1, 5'h12, {16'h0, v});
      rd(1, 5'h12, q);
      chk($sformatf("R10 v=0x%0h", v), q, {16'h0, port_expect(prev[15:0], v)});
    end

    summary();
  end
endmodule